// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block switches one gated logic domain between powered and unpowered states by stepping through a fixed series of control actions, each separated by a settle interval counted in clock cycles. It drives the domain's power switch (sleep), one power-down enable per memory bank, the isolation clamp, a domain reset and a clock enable. A caller pulses a request carrying the wanted state. The block answers with a one-cycle done pulse and shows the resulting state on a status output.

When going down, the switch opens first and the memories follow. Isolation clamps next, and the clock is gated last, after a long wait. When coming up, the switch closes and the memories wake. After that, reset is held across the isolation release, and the clock enable comes last. Parameters select a memory-only domain, which has no switch and no clamp, and a domain without a clock. A third parameter makes the domain come out of reset already powered. In that case the always-on input can hold it up.

Top module: `pwr_gate_seq`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, the outputs show the off state. In this state `sleep_o` and `iso_o` are 1 (0 in memory-only mode), every `mem_pd_o` bit is 1, `dom_rst_o` is 1, `clk_en_o` is 0, and `busy_o` and `done_o` are 0. When `BOOT_ON`=1 the outputs instead show the on state with `dom_rst_o` at 0.
- R2: A power-down is accepted on edge E0, one edge after the request is sampled. On E0 `sleep_o` rises. On E0+SETTLE_CYC all of `mem_pd_o` goes to 1. On E0+2*SETTLE_CYC `iso_o` rises. On E0+2*SETTLE_CYC+CLK_WAIT_CYC `clk_en_o` falls.
- R3: For a power-up accepted on E0, `sleep_o` falls on E0. On E0+SETTLE_CYC `mem_pd_o` clears to 0. `dom_rst_o` rises on E0+2*SETTLE_CYC, `iso_o` falls one edge later, and `dom_rst_o` falls one edge after that. `clk_en_o` rises on E0+2*SETTLE_CYC+3.
- R4: `mem_pd_o` holds one 2-bit field per bank, with bank b at bits [2b+1:2b]. A value of 1 means the bank is powered down. Both bits of a field and all fields change together.
- R5: With `MEM_ONLY`=1, `sleep_o` and `iso_o` stay 0. The memory step and both settle waits keep the same timing as R2 and R3.
- R6: With `HAS_CLK`=0, `clk_en_o` stays 0. A power-down ends on the isolation edge, E0+2*SETTLE_CYC, and a power-up ends on the reset-release edge, E0+2*SETTLE_CYC+2.
- R7: `pwr_on_o` is the inverse of `sleep_o`. In memory-only mode it is the inverse of `mem_pd_o[0]`.
- R8: With `BOOT_ON`=1, a power-down request is dropped while `always_on_i` is 1: no output moves and no done is given. This lock ends once a power-down has run.
- R9: A request that arrives while a sequence runs is held. It starts on the edge after that sequence's done.
- R10: A request for the state the domain is already in gives a done pulse on E0. No other output changes.
- R11: `done_o` is high for one cycle, on the edge of the final step. `busy_o` is 1 from E0 up to that edge and 0 from it onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | One-cycle request strobe |
| req_on_i | input | 1 | Requested state: 1 = powered, 0 = off |
| always_on_i | input | 1 | Keeps a boot-powered domain up |
| sleep_o | output | 1 | Power switch open (domain unpowered) |
| iso_o | output | 1 | Isolation clamp enable |
| mem_pd_o | output | 2*N_BANKS | Memory bank power-down fields |
| dom_rst_o | output | 1 | Domain reset, active high |
| clk_en_o | output | 1 | Domain clock enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence or no-op finished (one cycle) |
| pwr_on_o | output | 1 | Domain state: 1 = powered |

## Verification
On every cycle, the assertions check the ordering invariants. Isolation may only be released under reset. The clock may only rise once the domain is fully up, and may only fall after isolation and memory power-down. Memory fields move only during a busy sequence, and done never coincides with busy. The exact edge of each step, how long each wait lasts, whether a held or redundant request is handled correctly, and the always-on drop can only be shown by the bench's scenarios. The bench compares every output on every cycle against an arithmetic model of the step times.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DN_PSW,
    ST_DN_MEM,
    ST_DN_GATE,
    ST_UP_PSW,
    ST_UP_MEM,
    ST_UP_ISO,
    ST_UP_RLS,
    ST_UP_CLK
  } pg_state_e;
endpackage

// File: rtl/pgs_req_hold.sv
module pgs_req_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_on_i,
  input  logic take_i,
  output logic pend_o,
  output logic pend_on_o
);
  logic pend_q, on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      on_q   <= 1'b0;
    end else if (req_valid_i) begin
      pend_q <= 1'b1;
      on_q   <= req_on_i;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o    = pend_q;
  assign pend_on_o = on_q;
endmodule

// File: rtl/pgs_timer.sv
module pgs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
  import pwr_gate_pkg::*;
#(
  parameter int N_BANKS      = 4,
  parameter int SETTLE_CYC   = 5000,
  parameter int CLK_WAIT_CYC = 5000000,
  parameter bit MEM_ONLY     = 1'b0,
  parameter bit HAS_CLK      = 1'b1,
  parameter bit BOOT_ON      = 1'b0,
  parameter int CNT_W        = 23
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pend_i,
  input  logic               pend_on_i,
  input  logic               always_on_i,
  input  logic               tmr_zero_i,
  output logic               take_o,
  output logic               tmr_load_o,
  output logic [CNT_W-1:0]   tmr_val_o,
  output logic               sleep_o,
  output logic               iso_o,
  output logic [N_BANKS-1:0] bank_pd_o,
  output logic               dom_rst_o,
  output logic               clk_en_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               pwr_on_o
);
  localparam logic [CNT_W-1:0] SET_LD  = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] GATE_LD = CNT_W'(CLK_WAIT_CYC - 1);

  pg_state_e           st_q;
  logic                sleep_q, iso_q, rst_q, clk_q, done_q, lock_q;
  logic [N_BANKS-1:0]  bank_q;
  logic                pwr_on, go_up, go_dn, same;

  always_comb begin
    pwr_on     = MEM_ONLY ? !bank_q[0] : !sleep_q;
    take_o     = (st_q == ST_IDLE) && pend_i;
    same       = take_o && (pend_on_i == pwr_on);
    go_up      = take_o && pend_on_i && !pwr_on;
    go_dn      = take_o && !pend_on_i && pwr_on && !(lock_q && always_on_i);
    tmr_load_o = go_up || go_dn
              || (tmr_zero_i && (st_q == ST_DN_PSW || st_q == ST_UP_PSW))
              || (tmr_zero_i && HAS_CLK && st_q == ST_DN_MEM);
    tmr_val_o  = (st_q == ST_DN_MEM) ? GATE_LD : SET_LD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sleep_q <= !MEM_ONLY && !BOOT_ON;
      iso_q   <= !MEM_ONLY && !BOOT_ON;
      bank_q  <= BOOT_ON ? '0 : '1;
      rst_q   <= !BOOT_ON;
      clk_q   <= BOOT_ON && HAS_CLK;
      done_q  <= 1'b0;
      lock_q  <= BOOT_ON;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (go_dn) begin
            sleep_q <= !MEM_ONLY;
            lock_q  <= 1'b0;
            st_q    <= ST_DN_PSW;
          end else if (go_up) begin
            sleep_q <= 1'b0;
            st_q    <= ST_UP_PSW;
          end else if (same) begin
            done_q  <= 1'b1;
          end
        end
        ST_DN_PSW: if (tmr_zero_i) begin
          bank_q <= '1;
          st_q   <= ST_DN_MEM;
        end
        ST_DN_MEM: if (tmr_zero_i) begin
          iso_q <= !MEM_ONLY;
          if (HAS_CLK) st_q <= ST_DN_GATE;
          else begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_DN_GATE: if (tmr_zero_i) begin
          clk_q  <= 1'b0;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_UP_PSW: if (tmr_zero_i) begin
          bank_q <= '0;
          st_q   <= ST_UP_MEM;
        end
        ST_UP_MEM: if (tmr_zero_i) begin
          rst_q <= 1'b1;
          st_q  <= ST_UP_ISO;
        end
        ST_UP_ISO: begin
          iso_q <= 1'b0;
          st_q  <= ST_UP_RLS;
        end
        ST_UP_RLS: begin
          rst_q <= 1'b0;
          if (HAS_CLK) st_q <= ST_UP_CLK;
          else begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_UP_CLK: begin
          clk_q  <= 1'b1;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sleep_o   = sleep_q;
  assign iso_o     = iso_q;
  assign bank_pd_o = bank_q;
  assign dom_rst_o = rst_q;
  assign clk_en_o  = clk_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign pwr_on_o  = pwr_on;
endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
  parameter int N_BANKS      = 4,
  parameter int SETTLE_CYC   = 5000,
  parameter int CLK_WAIT_CYC = 5000000,
  parameter bit MEM_ONLY     = 1'b0,
  parameter bit HAS_CLK      = 1'b1,
  parameter bit BOOT_ON      = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_on_i,
  input  logic                 always_on_i,
  output logic                 sleep_o,
  output logic                 iso_o,
  output logic [2*N_BANKS-1:0] mem_pd_o,
  output logic                 dom_rst_o,
  output logic                 clk_en_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 pwr_on_o
);
  localparam int MAX_WAIT = (SETTLE_CYC > CLK_WAIT_CYC) ? SETTLE_CYC : CLK_WAIT_CYC;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  logic               pend, pend_on, take, tmr_load, tmr_zero;
  logic [CNT_W-1:0]   tmr_val;
  logic [N_BANKS-1:0] bank_pd;

  pgs_req_hold u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_on_i    (req_on_i),
    .take_i      (take),
    .pend_o      (pend),
    .pend_on_o   (pend_on)
  );

  pgs_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  pgs_fsm #(
    .N_BANKS      (N_BANKS),
    .SETTLE_CYC   (SETTLE_CYC),
    .CLK_WAIT_CYC (CLK_WAIT_CYC),
    .MEM_ONLY     (MEM_ONLY),
    .HAS_CLK      (HAS_CLK),
    .BOOT_ON      (BOOT_ON),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (pend),
    .pend_on_i   (pend_on),
    .always_on_i (always_on_i),
    .tmr_zero_i  (tmr_zero),
    .take_o      (take),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .sleep_o     (sleep_o),
    .iso_o       (iso_o),
    .bank_pd_o   (bank_pd),
    .dom_rst_o   (dom_rst_o),
    .clk_en_o    (clk_en_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .pwr_on_o    (pwr_on_o)
  );

  // each bank field is two identical enable bits
  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign mem_pd_o[2*b+1:2*b] = {2{bank_pd[b]}};
  end
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
  parameter int N_BANKS  = 4,
  parameter bit MEM_ONLY = 1'b0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sleep_o,
  input logic                 iso_o,
  input logic [2*N_BANKS-1:0] mem_pd_o,
  input logic                 dom_rst_o,
  input logic                 clk_en_o,
  input logic                 busy_o,
  input logic                 done_o
);
  p_iso_rel_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iso_o) |-> dom_rst_o);

  p_clk_up_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> (!dom_rst_o && !iso_o && !sleep_o && mem_pd_o == '0));

  p_clk_dn_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> ((&mem_pd_o) && (MEM_ONLY || (iso_o && sleep_o))));

  p_iso_after_mem_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_o) |-> ((&mem_pd_o) && sleep_o));

  p_mem_uniform_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ((&mem_pd_o) || (mem_pd_o == '0)));

  p_mem_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_pd_o) |-> $past(busy_o));

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  if (MEM_ONLY) begin : g_mo
    p_no_switch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (!sleep_o && !iso_o));
  end
endmodule

bind pwr_gate_seq pgs_checker #(.N_BANKS(N_BANKS), .MEM_ONLY(MEM_ONLY)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sleep_o   (sleep_o),
  .iso_o     (iso_o),
  .mem_pd_o  (mem_pd_o),
  .dom_rst_o (dom_rst_o),
  .clk_en_o  (clk_en_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/tb_pwr_gate_seq.sv
`timescale 1ns/1ps
module tb_pwr_gate_seq;
  localparam int S  = 5;
  localparam int C  = 12;
  localparam int NB = 3;
  localparam int MW = 2*NB;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [2:0] rv, ro, ao;
  logic [2:0] sl, is, dr, ce, by, dn, po;
  logic [MW-1:0] mp [3];
  bit [2:0] e_on, e_rst;
  int total = 0, bad = 0;

  pwr_gate_seq #(.N_BANKS(NB), .SETTLE_CYC(S), .CLK_WAIT_CYC(C),
                 .MEM_ONLY(1'b0), .HAS_CLK(1'b1), .BOOT_ON(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv[0]), .req_on_i(ro[0]),
    .always_on_i(ao[0]), .sleep_o(sl[0]), .iso_o(is[0]), .mem_pd_o(mp[0]),
    .dom_rst_o(dr[0]), .clk_en_o(ce[0]), .busy_o(by[0]), .done_o(dn[0]),
    .pwr_on_o(po[0]));

  pwr_gate_seq #(.N_BANKS(NB), .SETTLE_CYC(S), .CLK_WAIT_CYC(C),
                 .MEM_ONLY(1'b1), .HAS_CLK(1'b0), .BOOT_ON(1'b0)) dut_mem (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv[1]), .req_on_i(ro[1]),
    .always_on_i(ao[1]), .sleep_o(sl[1]), .iso_o(is[1]), .mem_pd_o(mp[1]),
    .dom_rst_o(dr[1]), .clk_en_o(ce[1]), .busy_o(by[1]), .done_o(dn[1]),
    .pwr_on_o(po[1]));

  pwr_gate_seq #(.N_BANKS(NB), .SETTLE_CYC(S), .CLK_WAIT_CYC(C),
                 .MEM_ONLY(1'b0), .HAS_CLK(1'b0), .BOOT_ON(1'b1)) dut_boot (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv[2]), .req_on_i(ro[2]),
    .always_on_i(ao[2]), .sleep_o(sl[2]), .iso_o(is[2]), .mem_pd_o(mp[2]),
    .dom_rst_o(dr[2]), .clk_en_o(ce[2]), .busy_o(by[2]), .done_o(dn[2]),
    .pwr_on_o(po[2]));

  function automatic bit memo(int i); return i == 1; endfunction
  function automatic bit hclk(int i); return i == 0; endfunction

  function automatic int fin_of(int i, bit on);
    if (on) return hclk(i) ? 2*S+3 : 2*S+2;
    return hclk(i) ? 2*S+C : 2*S;
  endfunction

  function automatic logic [MW+6:0] actual(int i);
    return {po[i], by[i], dn[i], ce[i], dr[i], is[i], sl[i], mp[i]};
  endfunction

  // kind: 0 = sequence, 1 = same-state request, 2 = no activity
  function automatic logic [MW+6:0] model(int i, bit on, int kind, int kk);
    bit m = memo(i), h = hclk(i);
    logic s_e, i_e, r_e, c_e, b_e, d_e, p_e;
    logic [MW-1:0] m_e;
    int fin = fin_of(i, on);
    if (e_on[i]) begin s_e = 0; i_e = 0; m_e = '0; c_e = h; end
    else begin s_e = !m; i_e = !m; m_e = '1; c_e = 0; end
    r_e = e_rst[i]; b_e = 0; d_e = 0;
    if (kind == 1) d_e = (kk == 0);
    else if (kind == 0 && !on) begin
      if (kk >= 0) s_e = !m;
      if (kk >= S) m_e = '1;
      if (kk >= 2*S) i_e = !m;
      if (h && kk >= 2*S+C) c_e = 0;
      b_e = (kk >= 0 && kk < fin); d_e = (kk == fin);
    end else if (kind == 0) begin
      if (kk >= 0) s_e = 0;
      if (kk >= S) m_e = '0;
      if (kk >= 2*S) r_e = 1;
      if (kk >= 2*S+1) i_e = 0;
      if (kk >= 2*S+2) r_e = 0;
      if (h && kk >= 2*S+3) c_e = 1;
      b_e = (kk >= 0 && kk < fin); d_e = (kk == fin);
    end
    p_e = m ? !m_e[0] : !s_e;
    return {p_e, b_e, d_e, c_e, r_e, i_e, s_e, m_e};
  endfunction

  task automatic chk(string tag, int i, int kk, logic [MW+6:0] exp);
    total++;
    if (actual(i) !== exp) begin
      bad++;
      $display("FAIL %s inst=%0d step=%0d got=%h exp=%h", tag, i, kk, actual(i), exp);
    end
  endtask

  task automatic issue(int i, bit on);
    rv[i] = 1'b1; ro[i] = on;
    @(posedge clk); @(negedge clk);
    rv[i] = 1'b0;
  endtask

  task automatic follow(string tag, int i, bit on, int kind, bit inject, int start);
    int last;
    if (kind == 0) last = inject ? fin_of(i, on) : fin_of(i, on) + 1;
    else last = (kind == 1) ? 1 : 4;
    for (int kk = start; kk <= last; kk++) begin
      chk(tag, i, kk, model(i, on, kind, kk));
      if (inject && kk == 2) begin rv[i] = 1'b1; ro[i] = !on; end
      else if (inject && kk == 3) rv[i] = 1'b0;
      if (kk < last) begin @(posedge clk); @(negedge clk); end
    end
    if (kind == 0) begin
      e_on[i] = on;
      if (on) e_rst[i] = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; rv = '0; ro = '0; ao = '0;
    e_on = 3'b100; e_rst = 3'b011;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 3; i++) chk("R1 in reset", i, -1, model(i, 0, 2, -1));
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < 3; i++) chk("R1 R8 after reset", i, -1, model(i, 0, 2, -1));

    // full domain with clock
    issue(0, 1); follow("R3 R4 R7 R11", 0, 1, 0, 0, -1);
    issue(0, 1); follow("R10", 0, 1, 1, 0, -1);
    issue(0, 0); follow("R2 R4 R7 R11", 0, 0, 0, 0, -1);
    issue(0, 1); follow("R9 first", 0, 1, 0, 1, -1);
    @(posedge clk); @(negedge clk);
    follow("R9 held", 0, 0, 0, 0, 0);

    // memory-only domain, no clock
    issue(1, 1); follow("R5 R6 up", 1, 1, 0, 0, -1);
    issue(1, 0); follow("R5 R6 down", 1, 0, 0, 0, -1);
    issue(1, 0); follow("R10 mem", 1, 0, 1, 0, -1);

    // boot-powered domain, no clock
    ao[2] = 1'b1;
    issue(2, 0); follow("R8 ignored", 2, 0, 2, 0, -1);
    ao[2] = 1'b0;
    follow("R8 no late start", 2, 0, 2, 0, 0);
    issue(2, 0); follow("R6 R8 down", 2, 0, 0, 0, -1);
    issue(2, 1); follow("R6 up", 2, 1, 0, 0, -1);
    ao[2] = 1'b1;
    issue(2, 0); follow("R8 unlocked", 2, 0, 0, 0, -1);

    summary();
  end
endmodule